// File: doc/BRIEF.md
# Microprogram Sequencer with Return Stack

This block steps through a 512-word by 36-bit microprogram held in an internal synchronous ROM. Each cycle it drives 16 registered control outputs from the current microword. It chooses the address of the next word from one of several sources: the incremented address, a branch target, a target gated by one selected test input, a counted loop, a subroutine call or return through a hardware stack, or a multiway target whose low three bits come from test inputs. The ROM image is a parameter, so an integrating design or a bench supplies the program at elaboration time.

The ROM output register is also the pipeline register. The word it holds is the instruction being executed, and its control fields decide the next address. That address goes straight to the ROM, so the sequencer completes one microinstruction per clock.

A microword is laid out as follows, from most significant bit to least:

- bits 35..31: operation code
- bits 30..27: test selector
- bit 26: polarity
- bits 25..17: branch address or loop count
- bit 16: reserved, written as zero
- bits 15..0: control outputs

Top module: `useq_top`

## Requirements
- R1: While `rst` is high at a clock edge, `cur_addr`, `user_out`, `stack_ovf` and `stack_unf` are zero. At the first edge with `rst` low, word 0 is fetched: `cur_addr` becomes 0 and `user_out` becomes bits 15..0 of word 0.
- R2: After every edge, `user_out` equals bits 15..0 of the ROM word whose address is shown on `cur_addr`. The two outputs change at the same edge.
- R3: Operation code 0 (continue), and every code above 7, go to `cur_addr`+1. The increment wraps from 511 to 0.
- R4: Operation code 1 (jump) goes to the 9-bit address field.
- R5: The condition is formed from the selector and the polarity bit. A selector of 0 to 7 picks test input n, a selector of 8 to 15 means constant 1, and the polarity bit inverts the result. Operation code 2 (conditional jump) goes to the address field when the condition is 1, and to `cur_addr`+1 otherwise.
- R6: Operation code 3 (call) acts only when the condition is 1. It then pushes `cur_addr`+1 and goes to the address field. Operation code 4 (return) also acts only when the condition is 1. It then pops the most recent entry and goes there. Both codes go to `cur_addr`+1 when the condition is 0, and returns come back in last-in, first-out order.
- R7: Operation code 5 loads the address field into the loop count and goes to `cur_addr`+1. Operation code 6 (loop) decrements a nonzero count and goes to the address field. With a count of zero it goes to `cur_addr`+1, so a body loaded with N runs N+1 times.
- R8: Operation code 7 (multiway) keeps bits 8..3 of the address field and replaces bits 2..0 with test inputs. The inputs are {t2,t1,t0} when selector bit 0 is 0, and {t7,t6,t5} when it is 1.
- R9: A call that finds all `STACK_DEPTH` entries full still branches, but it discards the return address, leaves the stack unchanged and sets `stack_ovf`. The flag stays set until reset.
- R10: A return that finds the stack empty goes to address 0 and sets `stack_unf`. The flag stays set until reset.
- R11: A test input whose bit is set in `TEST_REG_MASK` passes through one flip-flop, so decisions see its value from one edge earlier. The other test inputs act in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| test_in | input | 8 | Test inputs used by conditions and multiway branches |
| user_out | output | 16 | Registered control outputs of the executing word |
| cur_addr | output | 9 | Address of the executing word |
| stack_ovf | output | 1 | Sticky flag set by a push onto a full stack |
| stack_unf | output | 1 | Sticky flag set by a pop from an empty stack |

## Verification
Most internal faults reach `cur_addr` within one edge of the instruction that exposes them. A wrong decode or condition polarity puts the wrong address there at the very next edge. A wrong stack pointer or a lost stack entry stays hidden until a later return, which then lands on the wrong address. An off-by-one loop count shows as one extra or one missing pass through the body when the loop exits. Because the control outputs are tied to the word at `cur_addr`, any mismatch between the two also appears at once.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int PROG_WORDS = 512;
    localparam int AW         = $clog2(PROG_WORDS);
    localparam int IW         = 36;
    localparam int OW         = 16;
    localparam int NT         = 8;
    localparam int OPW        = 5;
    localparam int CSW        = 4;
    localparam int CTLW       = OPW + CSW + 1 + AW;

    typedef enum logic [OPW-1:0] {
        OP_CONT  = 5'd0,
        OP_JMP   = 5'd1,
        OP_CJMP  = 5'd2,
        OP_CALL  = 5'd3,
        OP_RET   = 5'd4,
        OP_LDCNT = 5'd5,
        OP_LOOP  = 5'd6,
        OP_MWAY  = 5'd7
    } op_e;

    typedef struct packed {
        op_e             op;
        logic [CSW-1:0]  csel;
        logic            cpol;
        logic [AW-1:0]   field;
    } ctl_t;

    typedef struct packed {
        ctl_t            ctl;
        logic [OW-1:0]   uout;
    } pipe_t;

    typedef logic [PROG_WORDS-1:0][IW-1:0] image_t;

    typedef struct packed {
        logic [AW-1:0] next_pc;
        logic          push;
        logic          pop;
        logic          cnt_load;
        logic          cnt_dec;
    } seq_ctl_t;

    function automatic logic cond_hit(input ctl_t c, input logic [NT-1:0] t);
        logic raw;
        raw = c.csel[CSW-1] ? 1'b1 : t[c.csel[2:0]];
        return raw ^ c.cpol;
    endfunction

    function automatic logic [AW-1:0] mway_target(input ctl_t c, input logic [NT-1:0] t);
        logic [2:0] low;
        low = c.csel[0] ? t[NT-1:NT-3] : t[2:0];
        return {c.field[AW-1:3], low};
    endfunction

    function automatic logic [AW-1:0] seq_inc(input logic [AW-1:0] a);
        return a + AW'(1);
    endfunction

endpackage

// File: rtl/useq_testin.sv
module useq_testin #(
    parameter int                       NT   = useq_pkg::NT,
    parameter logic [useq_pkg::NT-1:0]  MASK = '1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NT-1:0] raw_i,
    output logic [NT-1:0] eff_o
);

    for (genvar i = 0; i < NT; i++) begin : g_bit
        if (MASK[i]) begin : g_reg
            logic q_r;
            always_ff @(posedge clk) begin
                if (rst) q_r <= 1'b0;
                else     q_r <= raw_i[i];
            end
            assign eff_o[i] = q_r;
        end else begin : g_pass
            assign eff_o[i] = raw_i[i];
        end
    end

endmodule

// File: rtl/useq_stack.sv
module useq_stack #(
    parameter int DEPTH = 17,
    parameter int AW    = useq_pkg::AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [AW-1:0] din_i,
    output logic [AW-1:0] top_o,
    output logic          empty_o,
    output logic          ovf_o,
    output logic          unf_o
);

    localparam int PW = (DEPTH > 0) ? $clog2(DEPTH + 1) : 1;

    logic [PW-1:0] sp_q;
    logic          full;

    assign full    = (sp_q == PW'(DEPTH));
    assign empty_o = (sp_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q  <= '0;
            ovf_o <= 1'b0;
            unf_o <= 1'b0;
        end else begin
            if (push_i) begin
                if (full) ovf_o <= 1'b1;
                else      sp_q  <= sp_q + PW'(1);
            end
            if (pop_i) begin
                if (empty_o) unf_o <= 1'b1;
                else         sp_q  <= sp_q - PW'(1);
            end
        end
    end

    if (DEPTH > 0) begin : g_store
        logic [AW-1:0] mem_q [DEPTH];
        always_ff @(posedge clk) begin
            if (push_i && !full) mem_q[sp_q] <= din_i;
        end
        assign top_o = empty_o ? '0 : mem_q[sp_q - PW'(1)];
    end else begin : g_none
        assign top_o = '0;
    end

    // R6: the pointer never runs past the configured depth
    assert_sp_bound_R6: assert property (@(posedge clk) disable iff (rst)
        sp_q <= PW'(DEPTH));

    // R9: a push against a full stack leaves its occupancy alone
    assert_full_push_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (push_i && full) |=> $stable(sp_q));

    // R10: a pop from an empty stack leaves its occupancy alone
    assert_empty_pop_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (pop_i && empty_o) |=> (sp_q == '0));

endmodule

// File: rtl/useq_nextaddr.sv
module useq_nextaddr
    import useq_pkg::*;
(
    input  logic          run_i,
    input  ctl_t          ctl_i,
    input  logic [AW-1:0] pc_i,
    input  logic [NT-1:0] tests_i,
    input  logic          cnt_nz_i,
    input  logic [AW-1:0] stack_top_i,
    input  logic          stack_empty_i,
    output seq_ctl_t      seq_o
);

    logic          hit;
    logic [AW-1:0] inc;

    assign hit = cond_hit(ctl_i, tests_i);
    assign inc = seq_inc(pc_i);

    always_comb begin
        seq_o          = '0;
        seq_o.next_pc  = inc;
        if (!run_i) begin
            seq_o.next_pc = '0;
        end else begin
            case (ctl_i.op)
                OP_JMP:   seq_o.next_pc = ctl_i.field;
                OP_CJMP:  if (hit) seq_o.next_pc = ctl_i.field;
                OP_CALL: begin
                    if (hit) begin
                        seq_o.push    = 1'b1;
                        seq_o.next_pc = ctl_i.field;
                    end
                end
                OP_RET: begin
                    if (hit) begin
                        seq_o.pop     = 1'b1;
                        seq_o.next_pc = stack_empty_i ? '0 : stack_top_i;
                    end
                end
                OP_LDCNT: seq_o.cnt_load = 1'b1;
                OP_LOOP: begin
                    if (cnt_nz_i) begin
                        seq_o.cnt_dec = 1'b1;
                        seq_o.next_pc = ctl_i.field;
                    end
                end
                OP_MWAY:  seq_o.next_pc = mway_target(ctl_i, tests_i);
                default:  seq_o.next_pc = inc;
            endcase
        end
    end

endmodule

// File: rtl/useq_rom.sv
module useq_rom
    import useq_pkg::*;
#(
    parameter image_t IMAGE = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr_i,
    output pipe_t         pipe_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_o <= '0;
        end else begin
            pipe_o.ctl  <= ctl_t'(IMAGE[addr_i][IW-1:IW-CTLW]);
            pipe_o.uout <= IMAGE[addr_i][OW-1:0];
        end
    end

endmodule

// File: rtl/useq_top.sv
module useq_top
    import useq_pkg::*;
#(
    parameter int          STACK_DEPTH   = 17,
    parameter logic [7:0]  TEST_REG_MASK = 8'hFF,
    parameter image_t      PROG_IMAGE    = '0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  test_in,
    output logic [15:0] user_out,
    output logic [8:0]  cur_addr,
    output logic        stack_ovf,
    output logic        stack_unf
);

    logic          run_q;
    logic [AW-1:0] pc_q;
    logic [AW-1:0] cnt_q;
    pipe_t         pipe;
    logic [NT-1:0] tests_eff;
    seq_ctl_t      seq;
    logic [AW-1:0] stack_top;
    logic          stack_empty;
    logic [AW-1:0] exec_field;
    op_e           exec_op;

    assign exec_field = pipe.ctl.field;
    assign exec_op    = pipe.ctl.op;

    useq_testin #(.NT(NT), .MASK(TEST_REG_MASK)) u_testin (
        .clk   (clk),
        .rst   (rst),
        .raw_i (test_in),
        .eff_o (tests_eff)
    );

    useq_nextaddr u_next (
        .run_i         (run_q),
        .ctl_i         (pipe.ctl),
        .pc_i          (pc_q),
        .tests_i       (tests_eff),
        .cnt_nz_i      (|cnt_q),
        .stack_top_i   (stack_top),
        .stack_empty_i (stack_empty),
        .seq_o         (seq)
    );

    useq_stack #(.DEPTH(STACK_DEPTH), .AW(AW)) u_stack (
        .clk     (clk),
        .rst     (rst),
        .push_i  (seq.push),
        .pop_i   (seq.pop),
        .din_i   (seq_inc(pc_q)),
        .top_o   (stack_top),
        .empty_o (stack_empty),
        .ovf_o   (stack_ovf),
        .unf_o   (stack_unf)
    );

    useq_rom #(.IMAGE(PROG_IMAGE)) u_rom (
        .clk    (clk),
        .rst    (rst),
        .addr_i (seq.next_pc),
        .pipe_o (pipe)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            pc_q  <= '0;
            cnt_q <= '0;
        end else begin
            run_q <= 1'b1;
            pc_q  <= seq.next_pc;
            if (seq.cnt_load)     cnt_q <= exec_field;
            else if (seq.cnt_dec) cnt_q <= cnt_q - AW'(1);
        end
    end

    assign user_out = pipe.uout;
    assign cur_addr = pc_q;

    // R1: the first fetch after reset comes from address 0
    assert_start_zero_R1: assert property (@(posedge clk) disable iff (rst)
        !run_q |=> (pc_q == '0));

    // R3: sequential flow wraps at the top of the program space
    assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (run_q && exec_op == OP_CONT && pc_q == '1) |=> (pc_q == '0));

    // R6: one instruction never pushes and pops together
    assert_single_stack_op_R6: assert property (@(posedge clk) disable iff (rst)
        seq.push |-> !seq.pop);

    // R7: a taken loop decrements the count by exactly one
    assert_loop_dec_R7: assert property (@(posedge clk) disable iff (rst)
        (run_q && exec_op == OP_LOOP && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - AW'(1)));

    // R8: a multiway branch keeps the upper target bits
    assert_mway_base_R8: assert property (@(posedge clk) disable iff (rst)
        (run_q && exec_op == OP_MWAY) |=> (pc_q[AW-1:3] == $past(exec_field[AW-1:3])));

    // R10: a return on an empty stack restarts at address 0
    assert_empty_ret_R10: assert property (@(posedge clk) disable iff (rst)
        (seq.pop && stack_empty) |=> (pc_q == '0));

endmodule

// File: tb/useq_top_tb.sv
`timescale 1ns/1ps
module useq_top_tb;
    import useq_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  test_in = 8'h00;
    logic [15:0] user_out;
    logic [8:0]  cur_addr;
    logic        stack_ovf;
    logic        stack_unf;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    function automatic logic [35:0] mk(input logic [4:0] op, input logic [3:0] sel,
                                       input logic pol, input logic [8:0] fld,
                                       input logic [8:0] at);
        return {op, sel, pol, fld, 1'b0, 16'hC000 | {7'd0, at}};
    endfunction

    function automatic image_t build_img();
        image_t m = '0;
        m[0]   = mk(5'd0, 4'd0, 1'b0, 9'd0,   9'd0);
        m[1]   = mk(5'd1, 4'd0, 1'b0, 9'd10,  9'd1);
        m[10]  = mk(5'd2, 4'd0, 1'b0, 9'd20,  9'd10);
        m[11]  = mk(5'd2, 4'd1, 1'b1, 9'd14,  9'd11);
        m[12]  = mk(5'd2, 4'd8, 1'b0, 9'd20,  9'd12);
        m[14]  = mk(5'd3, 4'd8, 1'b0, 9'd100, 9'd14);
        m[15]  = mk(5'd4, 4'd8, 1'b0, 9'd0,   9'd15);
        m[20]  = mk(5'd3, 4'd8, 1'b0, 9'd40,  9'd20);
        m[21]  = mk(5'd5, 4'd0, 1'b0, 9'd2,   9'd21);
        m[22]  = mk(5'd0, 4'd0, 1'b0, 9'd0,   9'd22);
        m[23]  = mk(5'd6, 4'd0, 1'b0, 9'd22,  9'd23);
        m[24]  = mk(5'd7, 4'd0, 1'b0, 9'd64,  9'd24);
        m[40]  = mk(5'd3, 4'd2, 1'b0, 9'd50,  9'd40);
        m[41]  = mk(5'd3, 4'd8, 1'b0, 9'd50,  9'd41);
        m[42]  = mk(5'd4, 4'd8, 1'b0, 9'd0,   9'd42);
        m[50]  = mk(5'd4, 4'd3, 1'b0, 9'd0,   9'd50);
        m[51]  = mk(5'd4, 4'd8, 1'b0, 9'd0,   9'd51);
        m[69]  = mk(5'd7, 4'd1, 1'b0, 9'd72,  9'd69);
        m[77]  = mk(5'd2, 4'd7, 1'b0, 9'd80,  9'd77);
        m[78]  = mk(5'd2, 4'd7, 1'b0, 9'd80,  9'd78);
        m[80]  = mk(5'd1, 4'd0, 1'b0, 9'd510, 9'd80);
        m[100] = mk(5'd3, 4'd8, 1'b0, 9'd105, 9'd100);
        m[101] = mk(5'd4, 4'd8, 1'b0, 9'd0,   9'd101);
        m[105] = mk(5'd3, 4'd8, 1'b0, 9'd110, 9'd105);
        m[106] = mk(5'd4, 4'd8, 1'b0, 9'd0,   9'd106);
        m[110] = mk(5'd3, 4'd8, 1'b0, 9'd115, 9'd110);
        m[115] = mk(5'd4, 4'd8, 1'b0, 9'd0,   9'd115);
        m[510] = mk(5'd0, 4'd0, 1'b0, 9'd0,   9'd510);
        m[511] = mk(5'd31, 4'd0, 1'b0, 9'd0,  9'd511);
        return m;
    endfunction

    localparam image_t IMG = build_img();
    localparam int N_ROWS = 39;

    // each row: {test_in driven before the edge, cur_addr after it, stack_ovf, stack_unf}
    localparam logic [18:0] TRACE [N_ROWS] = '{
        {8'h00, 9'd0,   1'b0, 1'b0},  // 0  R1 first fetch
        {8'h00, 9'd1,   1'b0, 1'b0},  // 1  R3 continue
        {8'h00, 9'd10,  1'b0, 1'b0},  // 2  R4 jump
        {8'h00, 9'd11,  1'b0, 1'b0},  // 3  R5 t0=0 not taken
        {8'h02, 9'd12,  1'b0, 1'b0},  // 4  R5 inverted t1=1 not taken
        {8'h00, 9'd20,  1'b0, 1'b0},  // 5  R5 constant true
        {8'h00, 9'd40,  1'b0, 1'b0},  // 6  R6 call
        {8'h00, 9'd41,  1'b0, 1'b0},  // 7  R6 call not taken
        {8'h00, 9'd50,  1'b0, 1'b0},  // 8  R6 nested call
        {8'h00, 9'd51,  1'b0, 1'b0},  // 9  R6 return not taken
        {8'h00, 9'd42,  1'b0, 1'b0},  // 10 R6 return
        {8'h00, 9'd21,  1'b0, 1'b0},  // 11 R6 return LIFO
        {8'h00, 9'd22,  1'b0, 1'b0},  // 12 R7 load count 2
        {8'h00, 9'd23,  1'b0, 1'b0},  // 13
        {8'h00, 9'd22,  1'b0, 1'b0},  // 14 R7 loop back
        {8'h00, 9'd23,  1'b0, 1'b0},  // 15
        {8'h00, 9'd22,  1'b0, 1'b0},  // 16 R7 loop back
        {8'h00, 9'd23,  1'b0, 1'b0},  // 17
        {8'h00, 9'd24,  1'b0, 1'b0},  // 18 R7 exit
        {8'h85, 9'd69,  1'b0, 1'b0},  // 19 R8 low group 101
        {8'h20, 9'd77,  1'b0, 1'b0},  // 20 R8/R11 high group, t7 from one edge back
        {8'h80, 9'd78,  1'b0, 1'b0},  // 21 R11 t7 delayed, not taken
        {8'h00, 9'd80,  1'b0, 1'b0},  // 22 R11 t7 delayed, taken
        {8'h00, 9'd510, 1'b0, 1'b0},  // 23 R4
        {8'h00, 9'd511, 1'b0, 1'b0},  // 24 R3
        {8'h00, 9'd0,   1'b0, 1'b0},  // 25 R3 unused code, wrap
        {8'h00, 9'd1,   1'b0, 1'b0},  // 26
        {8'h00, 9'd10,  1'b0, 1'b0},  // 27
        {8'h00, 9'd11,  1'b0, 1'b0},  // 28 R5
        {8'h00, 9'd14,  1'b0, 1'b0},  // 29 R5 inverted t1=0 taken
        {8'h00, 9'd100, 1'b0, 1'b0},  // 30 R6
        {8'h00, 9'd105, 1'b0, 1'b0},  // 31 R9
        {8'h00, 9'd110, 1'b0, 1'b0},  // 32 R9 stack now full
        {8'h00, 9'd115, 1'b1, 1'b0},  // 33 R9 overflow still branches
        {8'h00, 9'd106, 1'b1, 1'b0},  // 34 R9 lost entry skipped
        {8'h00, 9'd101, 1'b1, 1'b0},  // 35 R9
        {8'h00, 9'd15,  1'b1, 1'b0},  // 36 R9
        {8'h00, 9'd0,   1'b1, 1'b1},  // 37 R10 empty return
        {8'h00, 9'd1,   1'b1, 1'b1}   // 38 R10 sticky
    };

    useq_top #(
        .STACK_DEPTH   (3),
        .TEST_REG_MASK (8'h80),
        .PROG_IMAGE    (IMG)
    ) u_dut (
        .clk       (clk),
        .rst       (rst),
        .test_in   (test_in),
        .user_out  (user_out),
        .cur_addr  (cur_addr),
        .stack_ovf (stack_ovf),
        .stack_unf (stack_unf)
    );

    task automatic chk(input string req, input string what,
                       input int unsigned act, input int unsigned exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic string row_req(input int r);
        case (r)
            0:                       return "R1";
            2, 23:                   return "R4";
            3, 4, 5, 28, 29:         return "R5";
            6, 7, 8, 9, 10, 11, 30:  return "R6";
            12, 13, 14, 15, 16, 17, 18: return "R7";
            19:                      return "R8";
            20, 21, 22:              return "R11";
            31, 32, 33, 34, 35, 36:  return "R9";
            37, 38:                  return "R10";
            default:                 return "R3";
        endcase
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        test_in = 8'h00;
        step();
        step();
        // R1 reset state
        chk("R1", "reset cur_addr", cur_addr, 0);
        chk("R1", "reset user_out", user_out, 0);
        chk("R1", "reset ovf", stack_ovf, 0);
        chk("R1", "reset unf", stack_unf, 0);
        rst = 1'b0;

        for (int r = 0; r < N_ROWS; r++) begin
            logic [18:0] row;
            row = TRACE[r];
            test_in = row[18:11];
            step();
            chk(row_req(r), "cur_addr", cur_addr, row[10:2]);
            // R2 outputs belong to the word at cur_addr
            chk("R2", "user_out", user_out, 16'hC000 | {7'd0, row[10:2]});
            chk("R9", "stack_ovf", stack_ovf, row[1]);
            chk("R10", "stack_unf", stack_unf, row[0]);
        end

        // R1 reset in mid-run clears flags and restarts at 0
        test_in = 8'h00;
        rst = 1'b1;
        step();
        chk("R1", "mid reset cur_addr", cur_addr, 0);
        chk("R1", "mid reset user_out", user_out, 0);
        chk("R1", "mid reset ovf", stack_ovf, 0);
        chk("R1", "mid reset unf", stack_unf, 0);
        rst = 1'b0;
        step();
        chk("R1", "restart cur_addr", cur_addr, 0);
        chk("R1", "restart user_out", user_out, 16'hC000);
        step();
        chk("R3", "after restart cur_addr", cur_addr, 1);
        chk("R2", "after restart user_out", user_out, 16'hC001);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule